// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers a large set of interrupt sources and presents one request line to a processor together with the vector of the source to serve. Most sources are level-sensitive hardware inputs. A few are flags that software sets and clears through the register port. Software can use those flags to signal another processor, or to split a handler into an urgent part and a deferred, lower-priority part. Each source carries a programmable 4-bit priority. A current-priority level masks every request at or below it, and software can raise that level to build a priority ceiling around a shared resource.

The processor acknowledges a request through the register port. The acknowledge saves the running level on a last-in first-out stack, raises the level to the priority of the winning source, and latches the vector for software to read. An end-of-interrupt write restores the saved level. A separate non-maskable input goes straight to a critical-interrupt output and bypasses arbitration and masking.

Register map. The map uses a 16-bit data bus and, with the default of 128 sources, an 8-bit address. Addresses 0x00 to 0x7F hold the priority of the source with that index in bits [3:0]. Address 0x80 holds the current priority and can be read and written. Address 0x81 takes a software-set write and reads back the flags. Address 0x82 takes a software-clear write. Address 0x83 takes the acknowledge write and reads back the latched vector. Address 0x84 takes the end-of-interrupt write. Any other address reads 0.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset, irq_o and crit_o (with nmi_in low) are 0. Every priority field reads 0, the current priority reads 0, the flags read 0 and the latched vector at 0x83 reads 0x1FF.
- R2: A write to address n (0 to 127) stores reg_wdata[3:0] as the priority of source n, and a read of address n returns that value in bits [3:0] with the other bits 0.
- R3: Software flag k is source k (0 to 7), and hw_irq bit j is source 8+j. The vector is the source index. irq_o and irq_vec_o follow a stimulus on the second rising edge after it.
- R4: The pending source with the highest priority wins. Among equal priorities, the lowest index wins.
- R5: irq_o is 1 only when the winning priority is strictly greater than the current priority. A source with priority 0 never raises irq_o.
- R6: A write to 0x81 sets the flags whose bits in reg_wdata[7:0] are 1. A write to 0x82 clears the flags whose bits are 1. Bits that are 0 leave their flags unchanged. The flags are read at 0x81.
- R7: A hardware source is pending exactly while its input is high. When the input falls, the request it caused is withdrawn.
- R8: An acknowledge (write to 0x83) while irq_o is 1 pushes the current priority, loads the winner's priority as the current priority, latches the vector at 0x83 and drops irq_o on the same edge. An acknowledge while irq_o is 0 latches 0x1FF and leaves the current priority unchanged.
- R9: An end-of-interrupt (write to 0x84) restores the most recently pushed priority. When the stack is empty, it leaves the current priority unchanged.
- R10: While a handler runs, a source of higher priority still requests and can be acknowledged. Successive end-of-interrupt writes restore the saved levels in reverse order of the pushes.
- R11: crit_o equals nmi_in in the same cycle, whatever the current priority.
- R12: Writing the current priority masks sources at or below the written level. A flag raised inside a handler is served only once an end-of-interrupt lowers the level below its priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_irq | input | 120 | Level-sensitive hardware requests, bit j is source 8+j |
| nmi_in | input | 1 | Non-maskable request |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from reg_addr |
| irq_o | output | 1 | Registered interrupt request |
| irq_vec_o | output | 9 | Vector of the requesting source |
| crit_o | output | 1 | Critical-interrupt output |

## Verification
Register writes take effect on the rising edge that ends the write cycle, so the bench reads them back at the falling edge after that edge. A hardware input passes through one synchronizing register, and the arbiter result passes through an output register, so irq_o and irq_vec_o settle on the second rising edge after any stimulus. The bench samples them at the falling edge after that second edge. The acknowledge drops irq_o on its own edge, and the bench checks it at the falling edge just after that edge. crit_o is combinational, so the bench checks it 1 ns after it drives nmi_in.

// File: rtl/pvi_pkg.sv
package pvi_pkg;

    localparam int PRIO_W = 4;
    localparam int VEC_W  = 9;
    localparam int DATA_W = 16;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [VEC_W-1:0]  vec_t;

    localparam vec_t SPURIOUS_VEC = '1;

    // Arbitration result
    typedef struct packed {
        logic  valid;
        vec_t  idx;
        prio_t prio;
    } win_t;

    // Control register selectors (low address bits in the control page)
    typedef enum logic [2:0] {
        CTL_CUR   = 3'd0,
        CTL_SWSET = 3'd1,
        CTL_SWCLR = 3'd2,
        CTL_ACK   = 3'd3,
        CTL_EOI   = 3'd4
    } ctl_sel_e;

    typedef struct packed {
        logic cur_we;
        logic sw_set;
        logic sw_clr;
        logic ack;
        logic eoi;
    } ctl_strobe_t;

    function automatic ctl_strobe_t decode_ctl(input logic hit, input logic [2:0] sel);
        ctl_strobe_t s;
        s = '0;
        if (hit) begin
            case (ctl_sel_e'(sel))
                CTL_CUR:   s.cur_we = 1'b1;
                CTL_SWSET: s.sw_set = 1'b1;
                CTL_SWCLR: s.sw_clr = 1'b1;
                CTL_ACK:   s.ack    = 1'b1;
                CTL_EOI:   s.eoi    = 1'b1;
                default:   s        = '0;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/pvi_src_bank.sv
module pvi_src_bank
    import pvi_pkg::*;
#(
    parameter int NUM_SRC = 128,
    parameter int NUM_SW  = 8
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_SRC-NUM_SW-1:0]        hw_irq,
    input  logic                             prio_we,
    input  logic [$clog2(NUM_SRC)-1:0]       prio_idx,
    input  prio_t                            prio_wdata,
    input  logic                             sw_set,
    input  logic                             sw_clr,
    input  logic [NUM_SW-1:0]                sw_mask,
    output logic [NUM_SRC-1:0]               pend,
    output logic [NUM_SRC-1:0][PRIO_W-1:0]   prio_tab,
    output logic [NUM_SW-1:0]                sw_flags
);

    localparam int NUM_HW = NUM_SRC - NUM_SW;

    logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
    logic [NUM_SW-1:0]              sw_q;
    logic [NUM_HW-1:0]              hw_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prio_q <= '0;
            sw_q   <= '0;
            hw_q   <= '0;
        end else begin
            hw_q <= hw_irq;
            if (prio_we) begin
                prio_q[prio_idx] <= prio_wdata;
            end
            if (sw_set) begin
                sw_q <= sw_q | sw_mask;
            end else if (sw_clr) begin
                sw_q <= sw_q & ~sw_mask;
            end
        end
    end

    // Software flags occupy the low indices, hardware lines follow
    assign pend     = {hw_q, sw_q};
    assign prio_tab = prio_q;
    assign sw_flags = sw_q;

    AST_SW_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (sw_clr && !sw_set) |=> ((sw_q & $past(sw_mask)) == '0)); // R6

    AST_SW_SET: assert property (@(posedge clk) disable iff (rst)
        sw_set |=> ((sw_q & $past(sw_mask)) == $past(sw_mask))); // R6

endmodule

// File: rtl/pvi_arbiter.sv
module pvi_arbiter
    import pvi_pkg::*;
#(
    parameter int NUM_SRC = 128
) (
    input  logic [NUM_SRC-1:0]             pend,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_tab,
    output win_t                           win
);

    // Scan from the top index down; ">=" lets a lower index take over a tie
    always_comb begin
        win = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend[i] && (!win.valid || prio_tab[i] >= win.prio)) begin
                win.valid = 1'b1;
                win.idx   = vec_t'(i);
                win.prio  = prio_tab[i];
            end
        end
    end

endmodule

// File: rtl/pvi_prio_stack.sv
module pvi_prio_stack
    import pvi_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  logic  pop,
    input  prio_t push_data,
    output prio_t top,
    output logic  empty
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0][PRIO_W-1:0] mem_q;
    logic [CNT_W-1:0]             cnt_q;
    logic                         full;

    assign full  = (cnt_q == CNT_W'(DEPTH));
    assign empty = (cnt_q == '0);
    assign top   = mem_q[PTR_W'(cnt_q - 1'b1)];

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_q <= '0;
            cnt_q <= '0;
        end else if (push && !full) begin
            mem_q[PTR_W'(cnt_q)] <= push_data;
            cnt_q                <= cnt_q + 1'b1;
        end else if (pop && !push && !empty) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    AST_STACK_TOP_PUSHED: assert property (@(posedge clk) disable iff (rst)
        (push && !full) |=> (top == $past(push_data))); // R10

    AST_STACK_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && empty) |=> empty); // R9

    AST_STACK_DEPTH_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(DEPTH)); // R10

endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
    import pvi_pkg::*;
#(
    parameter int NUM_SRC     = 128,
    parameter int NUM_SW      = 8,
    parameter int STACK_DEPTH = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_SRC-NUM_SW-1:0]     hw_irq,
    input  logic                          nmi_in,
    input  logic                          reg_we,
    input  logic [$clog2(NUM_SRC):0]      reg_addr,
    input  logic [DATA_W-1:0]             reg_wdata,
    output logic [DATA_W-1:0]             reg_rdata,
    output logic                          irq_o,
    output logic [VEC_W-1:0]              irq_vec_o,
    output logic                          crit_o
);

    localparam int IDX_W  = $clog2(NUM_SRC);
    localparam int ADDR_W = IDX_W + 1;

    logic [NUM_SRC-1:0]             pend;
    logic [NUM_SRC-1:0][PRIO_W-1:0] prio_tab;
    logic [NUM_SW-1:0]              sw_flags;
    win_t                           win;
    ctl_strobe_t                    ctl;
    logic                           ctl_hit;
    logic                           prio_we;
    logic                           ack_take;
    prio_t                          stk_top;
    logic                           stk_empty;

    prio_t cur_q;
    vec_t  ack_vec_q;
    logic  irq_q;
    vec_t  vec_q;
    prio_t wprio_q;

    // Address decode: upper half is the control page
    assign ctl_hit  = reg_we && reg_addr[ADDR_W-1] && (reg_addr[ADDR_W-2:3] == '0);
    assign ctl      = decode_ctl(ctl_hit, reg_addr[2:0]);
    assign prio_we  = reg_we && !reg_addr[ADDR_W-1];
    assign ack_take = ctl.ack && irq_q;

    pvi_src_bank #(.NUM_SRC(NUM_SRC), .NUM_SW(NUM_SW)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .hw_irq     (hw_irq),
        .prio_we    (prio_we),
        .prio_idx   (reg_addr[IDX_W-1:0]),
        .prio_wdata (reg_wdata[PRIO_W-1:0]),
        .sw_set     (ctl.sw_set),
        .sw_clr     (ctl.sw_clr),
        .sw_mask    (reg_wdata[NUM_SW-1:0]),
        .pend       (pend),
        .prio_tab   (prio_tab),
        .sw_flags   (sw_flags)
    );

    pvi_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .pend     (pend),
        .prio_tab (prio_tab),
        .win      (win)
    );

    pvi_prio_stack #(.DEPTH(STACK_DEPTH)) u_stack (
        .clk       (clk),
        .rst       (rst),
        .push      (ack_take),
        .pop       (ctl.eoi),
        .push_data (cur_q),
        .top       (stk_top),
        .empty     (stk_empty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q     <= '0;
            ack_vec_q <= SPURIOUS_VEC;
            irq_q     <= 1'b0;
            vec_q     <= '0;
            wprio_q   <= '0;
        end else begin
            // An accepted acknowledge withdraws the request on its own edge
            irq_q   <= win.valid && (win.prio > cur_q) && !ack_take;
            vec_q   <= win.idx;
            wprio_q <= win.prio;
            if (ctl.cur_we) begin
                cur_q <= reg_wdata[PRIO_W-1:0];
            end else if (ctl.ack) begin
                if (irq_q) begin
                    cur_q     <= wprio_q;
                    ack_vec_q <= vec_q;
                end else begin
                    ack_vec_q <= SPURIOUS_VEC;
                end
            end else if (ctl.eoi && !stk_empty) begin
                cur_q <= stk_top;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (!reg_addr[ADDR_W-1]) begin
            reg_rdata[PRIO_W-1:0] = prio_tab[reg_addr[IDX_W-1:0]];
        end else if (reg_addr[ADDR_W-2:3] == '0) begin
            case (ctl_sel_e'(reg_addr[2:0]))
                CTL_CUR:   reg_rdata[PRIO_W-1:0] = cur_q;
                CTL_SWSET: reg_rdata[NUM_SW-1:0] = sw_flags;
                CTL_ACK:   reg_rdata[VEC_W-1:0]  = ack_vec_q;
                default:   reg_rdata             = '0;
            endcase
        end
    end

    assign irq_o     = irq_q;
    assign irq_vec_o = vec_q;
    assign crit_o    = nmi_in;

    AST_IRQ_ABOVE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> (wprio_q > $past(cur_q))); // R5

    AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> (vec_q < VEC_W'(NUM_SRC))); // R3

    AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (rst)
        win.valid |-> pend[win.idx[IDX_W-1:0]]); // R4

    AST_ACK_RAISES_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (ctl.ack && irq_q) |=> (cur_q == $past(wprio_q))); // R8

    AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
        (ctl.ack && irq_q) |=> !irq_q); // R8

    AST_EOI_EMPTY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ctl.eoi && stk_empty) |=> $stable(cur_q)); // R9

endmodule

// File: tb/prio_vec_intc_tb.sv
module prio_vec_intc_tb;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [119:0] hw_irq = '0;
    logic         nmi_in = 1'b0;
    logic         reg_we = 1'b0;
    logic [7:0]   reg_addr = '0;
    logic [15:0]  reg_wdata = '0;
    logic [15:0]  reg_rdata;
    logic         irq_o;
    logic [8:0]   irq_vec_o;
    logic         crit_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk; // 200 MHz

    prio_vec_intc u_dut (
        .clk       (clk),
        .rst       (rst),
        .hw_irq    (hw_irq),
        .nmi_in    (nmi_in),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_o     (irq_o),
        .irq_vec_o (irq_vec_o),
        .crit_o    (crit_o)
    );

    localparam logic [7:0] A_CUR = 8'h80, A_SET = 8'h81, A_CLR = 8'h82, A_ACK = 8'h83, A_EOI = 8'h84;

    // sw mask, hw selector (b0:src8 b1:src9 b2:src20 b3:src127), level, irq, vector
    typedef struct packed {
        logic [7:0] sw;
        logic [3:0] hw;
        logic [3:0] cur;
        logic       irq;
        logic [8:0] vec;
    } row_t;

    localparam row_t TAB [13] = '{
        '{8'h01, 4'h0, 4'd0,  1'b1, 9'd0},    // R3 lone flag
        '{8'h21, 4'h0, 4'd0,  1'b1, 9'd5},    // R4 higher priority wins
        '{8'h21, 4'h1, 4'd0,  1'b1, 9'd5},    // R4 tie, lower index
        '{8'h00, 4'h1, 4'd0,  1'b1, 9'd8},    // R7 hardware source
        '{8'h00, 4'h5, 4'd0,  1'b1, 9'd20},   // R4
        '{8'h00, 4'hC, 4'd0,  1'b1, 9'd20},   // R4 tie among hardware
        '{8'h00, 4'h8, 4'd0,  1'b1, 9'd127},  // R3 top index
        '{8'h00, 4'h2, 4'd0,  1'b0, 9'd0},    // R5 priority zero
        '{8'h00, 4'hC, 4'd12, 1'b0, 9'd0},    // R5 equal to level
        '{8'h00, 4'h4, 4'd11, 1'b1, 9'd20},   // R5 one above level
        '{8'h21, 4'h0, 4'd9,  1'b0, 9'd0},    // R12 ceiling masks
        '{8'h21, 4'h0, 4'd3,  1'b1, 9'd5},    // R12 level lowered
        '{8'h00, 4'h0, 4'd0,  1'b0, 9'd0}     // R7 all withdrawn
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output int d);
        reg_addr = a;
        #1;
        d = int'(reg_rdata);
    endtask

    task automatic set_hw(input logic [3:0] s);
        hw_irq      = '0;
        hw_irq[0]   = s[0];
        hw_irq[1]   = s[1];
        hw_irq[12]  = s[2];
        hw_irq[119] = s[3];
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // Reset state
        check("R1 irq", int'(irq_o), 0);
        check("R1 crit", int'(crit_o), 0);
        rd(A_CUR, v);  check("R1 level", v, 0);
        rd(8'd20, v);  check("R1 prio", v, 0);
        rd(A_SET, v);  check("R1 flags", v, 0);
        rd(A_ACK, v);  check("R1 latched vector", v, 16'h1FF);

        // Priority programming, only bits [3:0] kept
        wr(8'd0, 16'd3);
        wr(8'd5, 16'hFFF9);
        wr(8'd8, 16'd9);
        wr(8'd20, 16'd12);
        wr(8'd127, 16'd12);
        wr(8'd9, 16'd0);
        rd(8'd5, v);   check("R2 masked field", v, 9);
        rd(8'd127, v); check("R2 top field", v, 12);

        // Flag set/clear semantics
        wr(A_SET, 16'h0021);
        rd(A_SET, v);  check("R6 set", v, 16'h21);
        wr(A_CLR, 16'h0001);
        rd(A_SET, v);  check("R6 clear", v, 16'h20);
        wr(A_CLR, 16'h0000);
        rd(A_SET, v);  check("R6 zero clear", v, 16'h20);
        wr(A_SET, 16'h0000);
        rd(A_SET, v);  check("R6 zero set", v, 16'h20);

        // Vector walk
        foreach (TAB[i]) begin
            wr(A_CLR, 16'h00FF);
            wr(A_SET, {8'h00, TAB[i].sw});
            set_hw(TAB[i].hw);
            wr(A_CUR, {12'h000, TAB[i].cur});
            tick();
            check($sformatf("R3/R4/R5 row %0d irq", i), int'(irq_o), int'(TAB[i].irq));
            if (TAB[i].irq) begin
                check($sformatf("R3/R4 row %0d vector", i), int'(irq_vec_o), int'(TAB[i].vec));
            end
        end

        // Acknowledge
        wr(A_CLR, 16'h00FF);
        wr(A_CUR, 16'd0);
        set_hw(4'h1);
        tick(); tick(); tick();
        check("R7 level request", int'(irq_o), 1);
        wr(A_ACK, 16'd0);
        check("R8 irq drops", int'(irq_o), 0);
        rd(A_ACK, v);  check("R8 latched vector", v, 8);
        rd(A_CUR, v);  check("R8 level raised", v, 9);
        tick();
        check("R8 stays masked", int'(irq_o), 0);
        wr(A_ACK, 16'd0);
        rd(A_ACK, v);  check("R8 spurious vector", v, 16'h1FF);
        rd(A_CUR, v);  check("R8 spurious keeps level", v, 9);

        // Nesting
        set_hw(4'h5);
        tick(); tick();
        check("R10 preempt irq", int'(irq_o), 1);
        check("R10 preempt vector", int'(irq_vec_o), 20);
        wr(A_ACK, 16'd0);
        rd(A_CUR, v);  check("R10 nested level", v, 12);
        wr(A_EOI, 16'd0);
        rd(A_CUR, v);  check("R10 first restore", v, 9);
        set_hw(4'h0);
        wr(A_SET, 16'h0001);
        tick(); tick();
        check("R12 deferred masked", int'(irq_o), 0);
        wr(A_EOI, 16'd0);
        rd(A_CUR, v);  check("R10 second restore", v, 0);
        tick();
        check("R12 deferred irq", int'(irq_o), 1);
        check("R12 deferred vector", int'(irq_vec_o), 0);
        wr(A_EOI, 16'd0);
        rd(A_CUR, v);  check("R9 empty at zero", v, 0);
        wr(A_CUR, 16'd5);
        wr(A_EOI, 16'd0);
        rd(A_CUR, v);  check("R9 empty keeps level", v, 5);

        // Non-maskable path
        wr(A_CUR, 16'd15);
        nmi_in = 1'b1;
        #1;
        check("R11 nmi high", int'(crit_o), 1);
        nmi_in = 1'b0;
        #1;
        check("R11 nmi low", int'(crit_o), 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule